// File: doc/BRIEF.md
# Multi-Stream Wall Clock Arbiter

This block owns a 64-bit wall clock value that several audio streams share. Outside logic tracks how far each stream has progressed. It presents each stream's absolute elapsed time, together with a mask that says which streams take part. A caller then asks for the wall clock to move to a new time. An ordinary request advances the clock only when every participating stream has already reached that time. The committed value is then the largest of the requested time and all participating streams' elapsed times. This keeps the shared clock from running ahead of any stream, and it also keeps the clock from falling behind the stream that is furthest along.

A force flag skips the progress check and writes the requested time directly. Each request produces a one-cycle result that says whether the committed clock now equals the requested time (accepted) or not (delayed). An ordinary request that would leave the clock where it is, or move it backwards, does not change the clock and counts as stale. A stale-update warning is raised once more than three such stale updates have occurred since the last advance.

Top module: `wclk_arbiter`

## Requirements
- R1: While `rst` is high, and after it is released, `wall_time` is 0 and `result_valid`, `result_ok` and `stale_warn` are 0.
- R2: A non-forced request succeeds only if `stream_elapsed` of every active stream is greater than or equal to `req_time`. If any active stream is behind `req_time`, `wall_time` keeps its value.
- R3: When a non-forced request passes the check of R2 and its candidate is larger than `wall_time`, `wall_time` becomes the candidate on the edge that samples the request. The candidate is the maximum of `req_time` and the elapsed times of all active streams.
- R4: A forced request (`req_force`=1) writes `req_time` into `wall_time` whatever the stream progress and the current value, and it clears the stale count.
- R5: A non-forced request never lowers `wall_time`. A candidate below the current value leaves the clock unchanged and counts as stale.
- R6: A candidate equal to the current value also counts as stale. `stale_warn` is 1 while the stale count is greater than 3, so it is set by the 4th stale update after the last clear. Every real advance clears the count to 0, which drops `stale_warn` at once.
- R7: Each request sampled on an edge makes `result_valid` 1 for exactly the following cycle. In that cycle `result_ok` is 1 if the committed `wall_time` equals the request's `req_time`, and 0 otherwise (delayed).
- R8: A stream whose bit in `stream_active` is 0 counts as passed for R2 and does not contribute to the candidate of R3. Stream i uses bit i of `stream_active` and bits [64*i+63 : 64*i] of `stream_elapsed`.
- R9: With `req_valid` low, `wall_time` and the stale count keep their values and `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Update request strobe, one request per cycle |
| req_time | input | 64 | Requested wall clock value |
| req_force | input | 1 | Write `req_time` directly, skipping all checks |
| stream_active | input | 3 | Participation mask, bit i for stream i |
| stream_elapsed | input | 192 | Absolute elapsed time per stream, stream i at bits 64*i upward |
| wall_time | output | 64 | Current wall clock value |
| result_valid | output | 1 | One-cycle pulse after each request |
| result_ok | output | 1 | 1 if the committed clock equals the requested value |
| stale_warn | output | 1 | Stale-update count has passed its limit |

## Verification
The hardest state to reach is the stale warning. Reaching it takes four stale updates in a row with no advance or force between them. Each of those updates must also pass the progress gate while its candidate is equal to or below the current clock, which is awkward when streams are active. The stimulus table gets there by first driving the clock forward. It then clears the activity mask, so that every request passes and only its own value sets the candidate. Requests equal to and below the clock then build the count to the limit, and a final advancing request and a forced write check that the count is cleared.

// File: rtl/wclk_pkg.sv
package wclk_pkg;

    localparam int WCLK_TIME_W     = 64;
    localparam int WCLK_STREAMS    = 3;
    localparam int WCLK_STALE_MAX  = 3;

    // What a sampled request does to the clock register.
    typedef enum logic [2:0] {
        WC_IDLE    = 3'd0,  // no request this cycle
        WC_HOLD    = 3'd1,  // some active stream has not reached the request
        WC_ADVANCE = 3'd2,  // candidate is ahead of the clock
        WC_STALE   = 3'd3,  // candidate is not ahead of the clock
        WC_FORCE   = 3'd4   // direct write
    } wc_action_e;

    typedef struct packed {
        wc_action_e action;
        logic       write_clock;  // load the clock register
        logic       count_stale;  // bump the stale counter
        logic       clear_stale;  // zero the stale counter
    } wc_step_t;

    function automatic wc_step_t wc_classify(
        input logic req_valid,
        input logic req_force,
        input logic all_passed,
        input logic ahead,
        input logic equal_or_behind
    );
        wc_step_t s;
        s = '{action: WC_IDLE, write_clock: 1'b0, count_stale: 1'b0, clear_stale: 1'b0};
        if (req_valid) begin
            if (req_force) begin
                s.action      = WC_FORCE;
                s.write_clock = 1'b1;
                s.clear_stale = 1'b1;
            end else if (!all_passed) begin
                s.action = WC_HOLD;
            end else if (ahead) begin
                s.action      = WC_ADVANCE;
                s.write_clock = 1'b1;
                s.clear_stale = 1'b1;
            end else if (equal_or_behind) begin
                s.action      = WC_STALE;
                s.count_stale = 1'b1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/wclk_progress.sv
module wclk_progress #(
    parameter int N_STREAMS = wclk_pkg::WCLK_STREAMS,
    parameter int TIME_W    = wclk_pkg::WCLK_TIME_W
) (
    input  logic [N_STREAMS-1:0]        active,
    input  logic [N_STREAMS*TIME_W-1:0] elapsed,
    input  logic [TIME_W-1:0]           req_time,
    output logic                        all_passed,
    output logic [TIME_W-1:0]           peak
);

    logic [N_STREAMS-1:0] passed_vec;
    logic [TIME_W-1:0]    contrib [N_STREAMS];

    for (genvar i = 0; i < N_STREAMS; i++) begin : g_stream
        logic [TIME_W-1:0] e_i;
        assign e_i           = elapsed[i*TIME_W +: TIME_W];
        assign passed_vec[i] = !active[i] || (e_i >= req_time);
        assign contrib[i]    = active[i] ? e_i : '0;
    end

    assign all_passed = &passed_vec;

    always_comb begin
        peak = req_time;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (contrib[i] > peak) peak = contrib[i];
        end
    end

    // R8: a masked stream can never block the gate
    always_comb begin
        if (active == '0) begin
            a_r8_masked_pass: assert (all_passed);
        end
    end

endmodule

// File: rtl/wclk_stale.sv
module wclk_stale #(
    parameter int LIMIT = wclk_pkg::WCLK_STALE_MAX,
    localparam int CNT_W = $clog2(LIMIT + 2) + 1,
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}}
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    input  logic clear,
    output logic warn
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (bump && cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign warn = (cnt_q > CNT_W'(LIMIT));

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    a_r6_warn_on_limit: assert property (@(posedge clk) disable iff (rst)
        (bump && !clear && cnt_q == CNT_W'(LIMIT)) |=> warn);

    a_r9_hold_count: assert property (@(posedge clk) disable iff (rst)
        (!bump && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wclk_arbiter.sv
module wclk_arbiter
    import wclk_pkg::*;
#(
    parameter int N_STREAMS = WCLK_STREAMS,
    parameter int TIME_W    = WCLK_TIME_W,
    parameter int STALE_MAX = WCLK_STALE_MAX
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [TIME_W-1:0]           req_time,
    input  logic                        req_force,
    input  logic [N_STREAMS-1:0]        stream_active,
    input  logic [N_STREAMS*TIME_W-1:0] stream_elapsed,
    output logic [TIME_W-1:0]           wall_time,
    output logic                        result_valid,
    output logic                        result_ok,
    output logic                        stale_warn
);

    logic              all_passed;
    logic [TIME_W-1:0] peak;
    logic [TIME_W-1:0] wall_q;
    logic [TIME_W-1:0] wall_d;
    wc_step_t          step;

    wclk_progress #(
        .N_STREAMS(N_STREAMS),
        .TIME_W   (TIME_W)
    ) u_progress (
        .active    (stream_active),
        .elapsed   (stream_elapsed),
        .req_time  (req_time),
        .all_passed(all_passed),
        .peak      (peak)
    );

    always_comb begin
        step = wc_classify(req_valid, req_force, all_passed,
                           peak > wall_q, peak <= wall_q);
        wall_d = wall_q;
        if (step.write_clock) begin
            wall_d = (step.action == WC_FORCE) ? req_time : peak;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wall_q       <= '0;
            result_valid <= 1'b0;
            result_ok    <= 1'b0;
        end else begin
            wall_q       <= wall_d;
            result_valid <= req_valid;
            result_ok    <= req_valid && (wall_d == req_time);
        end
    end

    wclk_stale #(
        .LIMIT(STALE_MAX)
    ) u_stale (
        .clk  (clk),
        .rst  (rst),
        .bump (step.count_stale),
        .clear(step.clear_stale),
        .warn (stale_warn)
    );

    assign wall_time = wall_q;

    a_r2_hold_when_behind: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_force && !all_passed) |=> $stable(wall_q));

    a_r4_force_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_force) |=> (wall_q == $past(req_time)));

    a_r5_no_backwards: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_force) |=> (wall_q >= $past(wall_q)));

    a_r3_not_below_request: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_force && all_passed && peak > wall_q) |=> (wall_q >= $past(req_time)));

    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> result_valid);

    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!result_valid && $stable(wall_q)));

endmodule

// File: tb/tb_wclk_arbiter.sv
module tb_wclk_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int TW = 64;

    typedef struct packed {
        logic [2:0]    act;
        logic [TW-1:0] e0;
        logic [TW-1:0] e1;
        logic [TW-1:0] e2;
        logic [TW-1:0] req;
        logic          frc;
        logic [TW-1:0] x_wall;
        logic          x_ok;
        logic          x_warn;
    } vec_t;

    localparam int NV = 13;
    // act, e0, e1, e2, req, force, expected wall, ok, warn
    localparam vec_t VEC [NV] = '{
        '{3'b111, 64'd100, 64'd120, 64'd110, 64'd90,  1'b0, 64'd120, 1'b0, 1'b0}, // R3 max from stream
        '{3'b111, 64'd150, 64'd140, 64'd160, 64'd140, 1'b0, 64'd160, 1'b0, 1'b0}, // R3
        '{3'b111, 64'd200, 64'd200, 64'd200, 64'd200, 1'b0, 64'd200, 1'b1, 1'b0}, // R3 exact, R7 ok
        '{3'b111, 64'd250, 64'd180, 64'd260, 64'd220, 1'b0, 64'd200, 1'b0, 1'b0}, // R2 stream1 behind
        '{3'b011, 64'd320, 64'd310, 64'd999, 64'd300, 1'b0, 64'd320, 1'b0, 1'b0}, // R8 stream2 masked
        '{3'b111, 64'd320, 64'd320, 64'd320, 64'd320, 1'b0, 64'd320, 1'b1, 1'b0}, // R6 stale 1
        '{3'b000, 64'd0,   64'd0,   64'd0,   64'd100, 1'b0, 64'd320, 1'b0, 1'b0}, // R5 stale 2
        '{3'b000, 64'd0,   64'd0,   64'd0,   64'd50,  1'b0, 64'd320, 1'b0, 1'b0}, // R5 stale 3
        '{3'b000, 64'd0,   64'd0,   64'd0,   64'd320, 1'b0, 64'd320, 1'b1, 1'b1}, // R6 stale 4 warn
        '{3'b000, 64'd0,   64'd0,   64'd0,   64'd400, 1'b0, 64'd400, 1'b1, 1'b0}, // R6 advance clears
        '{3'b111, 64'd0,   64'd0,   64'd0,   64'd10,  1'b1, 64'd10,  1'b1, 1'b0}, // R4 force back
        '{3'b111, 64'd0,   64'd0,   64'd0,   64'd10,  1'b1, 64'd10,  1'b1, 1'b0}, // R4 force same
        '{3'b111, 64'd5,   64'd5,   64'd5,   64'd8,   1'b0, 64'd10,  1'b0, 1'b0}  // R2 behind
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [TW-1:0]     req_time;
    logic              req_force;
    logic [NS-1:0]     stream_active;
    logic [NS*TW-1:0]  stream_elapsed;
    logic [TW-1:0]     wall_time;
    logic              result_valid;
    logic              result_ok;
    logic              stale_warn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wclk_arbiter dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_time      (req_time),
        .req_force     (req_force),
        .stream_active (stream_active),
        .stream_elapsed(stream_elapsed),
        .wall_time     (wall_time),
        .result_valid  (result_valid),
        .result_ok     (result_ok),
        .stale_warn    (stale_warn)
    );

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] act, input logic [TW-1:0] e0, input logic [TW-1:0] e1,
                         input logic [TW-1:0] e2, input logic [TW-1:0] rq, input logic frc);
        req_valid      = 1'b1;
        req_time       = rq;
        req_force      = frc;
        stream_active  = act;
        stream_elapsed = {e2, e1, e0};
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_time = '0; req_force = 1'b0;
        stream_active = '0; stream_elapsed = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 wall during reset", wall_time, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 wall after reset", wall_time, 0);
        check("R1 result_valid", {63'd0, result_valid}, 0);
        check("R1 stale_warn", {63'd0, stale_warn}, 0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].act, VEC[i].e0, VEC[i].e1, VEC[i].e2, VEC[i].req, VEC[i].frc);
            check($sformatf("R3/R2 vec%0d wall", i), wall_time, VEC[i].x_wall);
            check($sformatf("R7 vec%0d valid", i), {63'd0, result_valid}, 1);
            check($sformatf("R7 vec%0d ok", i), {63'd0, result_ok}, {63'd0, VEC[i].x_ok});
            check($sformatf("R6 vec%0d warn", i), {63'd0, stale_warn}, {63'd0, VEC[i].x_warn});
        end

        // R9: idle cycles keep clock, pulse drops
        stream_active = 3'b111; stream_elapsed = {3{64'd5000}}; req_time = 64'd4000;
        repeat (3) @(negedge clk);
        check("R9 idle wall", wall_time, 10);
        check("R9 idle valid", {63'd0, result_valid}, 0);

        // R6: build four stale updates then force clears the warning
        for (int k = 0; k < 4; k++) issue(3'b000, 0, 0, 0, 64'd3, 1'b0);
        check("R6 warn after four stale", {63'd0, stale_warn}, 1);
        check("R5 wall kept on lower request", wall_time, 10);
        issue(3'b000, 0, 0, 0, 64'd3, 1'b0);
        check("R6 warn stays", {63'd0, stale_warn}, 1);
        issue(3'b111, 0, 0, 0, 64'd7, 1'b1);
        check("R4 force clears warn", {63'd0, stale_warn}, 0);
        check("R4 force wall", wall_time, 7);

        // R8: masked stream far behind does not block
        issue(3'b110, 64'd0, 64'd50, 64'd40, 64'd30, 1'b0);
        check("R8 masked behind stream", wall_time, 50);

        // R1: reset mid-run returns to zero
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", wall_time, 0);
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule